// File: doc/BRIEF.md
# Debug Port Unlock Key Checker

This block guards a chip's test access port. When the security strap is high, both emulation access and booting from external memory stay locked after reset. They open only once the correct secret key has been scanned in through a dedicated test data register. The key is compared against a stored value supplied from outside the block, for example from fuses or ROM.

The block sits behind the TAP controller. It receives the controller's capture, shift and update strobes for the key register, already qualified by the instruction decode, along with the serial input bit. It returns the register's serial output and two unlock flags.

A key that does not match is dropped without any trace. One matching scan opens both features together, and they stay open until the next reset. When the strap is low, the part is unsecured and both flags are high as soon as reset ends.

Top module: `dbg_unlock_gate`

## Requirements
- R1: While `rst` is high with `sec_en` high, and in the first cycle after `rst` falls, `emu_unlock` and `boot_unlock` are 0 and `tdo` is 0.
- R2: If `sec_en` is low at the last reset edge, `emu_unlock` and `boot_unlock` are 1 from the first cycle after reset. `sec_en` is a strap and is treated as static outside reset.
- R3: A clock edge with `dr_capture` high clears every bit of the 64-bit key register. Bits left over from an earlier scan can never merge with a later one. Capture takes priority over shift and update when they coincide.
- R4: A clock edge with `dr_shift` high, and `dr_capture` low, moves the key register one place toward bit 0 and loads `tdi` into bit 63. The key is therefore sent least significant bit first.
- R5: `tdo` always equals bit 0 of the key register. After a full key has been shifted in, further shifting returns that key on `tdo`, bit 0 first.
- R6: A clock edge with `dr_update` high, while the register equals `stored_key`, sets both flags. The flags read 1 from the following cycle.
- R7: An update while the register differs from `stored_key` changes neither flag.
- R8: Once set, the flags stay set until reset, whatever keys are scanned afterwards.
- R9: The flags change only on an update edge. A matching key that sits in the register without an update leaves them clear.
- R10: `emu_unlock` and `boot_unlock` are always equal.
- R11: `stored_key` never reaches `tdo`. After a capture, shifting in zeros returns only zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en | input | 1 | Security strap; high means the part starts locked |
| dr_capture | input | 1 | Capture strobe for the key register |
| dr_shift | input | 1 | Shift strobe for the key register |
| dr_update | input | 1 | Update strobe; triggers the key comparison |
| tdi | input | 1 | Serial data in |
| stored_key | input | 64 | Secret key to compare against |
| tdo | output | 1 | Serial data out (key register bit 0) |
| emu_unlock | output | 1 | Emulation access allowed |
| boot_unlock | output | 1 | External boot allowed |

## Verification
The bench first scans a long word whose upper half equals the lower half of the secret key. It then captures and shifts in only the key's upper half before updating. A design that skipped the clear on capture would splice these into the full key and unlock.

The bench also leaves a correct key sitting in the register across idle cycles with no update. A design that compared continuously would open early.

Wrong keys are scanned both before and after a successful unlock. This catches a design that relocks or drifts on a mismatch.

Finally, shifting zeros through both before and after a real key checks two things. It catches bit order reversal on `tdo`, and it catches any path that leaks the stored key onto the output.

// File: rtl/dbg_unlock_pkg.sv
package dbg_unlock_pkg;

    localparam int KEY_W_DEF = 64;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } tap_op_e;

    typedef struct packed {
        logic emu;
        logic boot;
    } unlock_t;

    // Capture wins over shift, shift over update.
    function automatic tap_op_e decode_op(input logic cap, input logic sh, input logic upd);
        tap_op_e op;
        if (cap)      op = OP_CAPTURE;
        else if (sh)  op = OP_SHIFT;
        else if (upd) op = OP_UPDATE;
        else          op = OP_IDLE;
        return op;
    endfunction

    function automatic unlock_t unlock_all(input logic v);
        unlock_t u;
        u.emu  = v;
        u.boot = v;
        return u;
    endfunction

endpackage

// File: rtl/key_shift_reg.sv
module key_shift_reg
    import dbg_unlock_pkg::*;
#(
    parameter int KEY_W = KEY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  tap_op_e          op,
    input  logic             tdi,
    output logic [KEY_W-1:0] sr_o,
    output logic             tdo
);
    logic [KEY_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            case (op)
                OP_CAPTURE: sr_q <= '0;
                OP_SHIFT:   sr_q <= {tdi, sr_q[KEY_W-1:1]};
                default:    sr_q <= sr_q;
            endcase
        end
    end

    assign sr_o = sr_q;
    assign tdo  = sr_q[0];
endmodule

// File: rtl/key_compare.sv
module key_compare
    import dbg_unlock_pkg::*;
#(
    parameter int KEY_W = KEY_W_DEF,
    parameter int SLICE = 16
) (
    input  tap_op_e          op,
    input  logic [KEY_W-1:0] candidate,
    input  logic [KEY_W-1:0] secret,
    output logic             accept_o
);
    localparam int NSL = (KEY_W + SLICE - 1) / SLICE;

    logic [NSL-1:0] slice_eq;

    // Balanced compare: per-slice equality, then a reduction AND.
    for (genvar g = 0; g < NSL; g++) begin : g_slice
        localparam int LO = g * SLICE;
        localparam int HI = ((g + 1) * SLICE > KEY_W) ? KEY_W - 1 : (g + 1) * SLICE - 1;
        assign slice_eq[g] = (candidate[HI:LO] == secret[HI:LO]);
    end

    assign accept_o = (op == OP_UPDATE) && (&slice_eq);
endmodule

// File: rtl/unlock_latch.sv
module unlock_latch
    import dbg_unlock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sec_en,
    input  logic    accept,
    output unlock_t state_o
);
    unlock_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= unlock_all(~sec_en);
        end else if (accept) begin
            st_q <= unlock_all(1'b1);
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/dbg_unlock_gate.sv
module dbg_unlock_gate
    import dbg_unlock_pkg::*;
#(
    parameter int KEY_W = KEY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_en,
    input  logic             dr_capture,
    input  logic             dr_shift,
    input  logic             dr_update,
    input  logic             tdi,
    input  logic [KEY_W-1:0] stored_key,
    output logic             tdo,
    output logic             emu_unlock,
    output logic             boot_unlock
);
    tap_op_e          op;
    logic [KEY_W-1:0] sr;
    logic             accept;
    unlock_t          st;

    assign op = decode_op(dr_capture, dr_shift, dr_update);

    key_shift_reg #(.KEY_W(KEY_W)) u_sr (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .tdi (tdi),
        .sr_o(sr),
        .tdo (tdo)
    );

    key_compare #(.KEY_W(KEY_W)) u_cmp (
        .op       (op),
        .candidate(sr),
        .secret   (stored_key),
        .accept_o (accept)
    );

    unlock_latch u_lat (
        .clk    (clk),
        .rst    (rst),
        .sec_en (sec_en),
        .accept (accept),
        .state_o(st)
    );

    assign emu_unlock  = st.emu;
    assign boot_unlock = st.boot;
endmodule

// File: rtl/dbg_unlock_gate_chk.sv
module dbg_unlock_gate_chk (
    input logic clk,
    input logic rst,
    input logic sec_en,
    input logic dr_capture,
    input logic dr_update,
    input logic tdo,
    input logic emu_unlock,
    input logic boot_unlock
);
    // R10
    pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
        emu_unlock == boot_unlock);

    // R8
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        emu_unlock |=> emu_unlock);

    // R9
    rise_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(emu_unlock) |-> $past(dr_update));

    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !dr_update |=> $stable(emu_unlock) && $stable(boot_unlock));

    // R3
    capture_clears_chk: assert property (@(posedge clk) disable iff (rst)
        dr_capture |=> !tdo);

    // R2
    strap_open_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_en |-> emu_unlock);
endmodule

bind dbg_unlock_gate dbg_unlock_gate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_en     (sec_en),
    .dr_capture (dr_capture),
    .dr_update  (dr_update),
    .tdo        (tdo),
    .emu_unlock (emu_unlock),
    .boot_unlock(boot_unlock)
);

// File: tb/dbg_unlock_gate_test.sv
module dbg_unlock_gate_test;
    localparam logic [63:0] KEY = 64'hA5C3_1E7F_0B96_D248;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_en = 1'b1;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
    logic tdo, emu_unlock, boot_unlock;
    logic [63:0] outbits;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_unlock_gate uut (
        .clk(clk), .rst(rst), .sec_en(sec_en),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .stored_key(KEY),
        .tdo(tdo), .emu_unlock(emu_unlock), .boot_unlock(boot_unlock)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        @(negedge clk);
        sec_en = strap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Shift nbits of v, LSB first; outbits records tdo before each edge.
    task automatic scan(input logic [63:0] v, input int nbits, input bit cap, input bit upd);
        outbits = '0;
        if (cap) begin
            dr_capture = 1'b1;
            @(negedge clk);
            dr_capture = 1'b0;
        end
        for (int i = 0; i < nbits; i++) begin
            dr_shift = 1'b1;
            tdi = v[i];
            outbits[i] = tdo;
            @(negedge clk);
        end
        dr_shift = 1'b0;
        tdi = 1'b0;
        if (upd) begin
            dr_update = 1'b1;
            @(negedge clk);
            dr_update = 1'b0;
        end
    endtask

    task automatic t_reset_locked();
        rst = 1'b1;
        sec_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(emu_unlock == 0 && boot_unlock == 0, "R1 in reset", {emu_unlock, boot_unlock}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(emu_unlock == 0 && boot_unlock == 0, "R1 after reset", {emu_unlock, boot_unlock}, 0);
        chk(tdo == 0, "R1 tdo", tdo, 0);
    endtask

    task automatic t_wrong_key();
        scan(KEY ^ 64'h1, 64, 1, 1);
        chk(emu_unlock == 0 && boot_unlock == 0, "R7 wrong key", {emu_unlock, boot_unlock}, 0);
        scan(64'h0, 64, 1, 1);
        chk(emu_unlock == 0, "R7 zero key", emu_unlock, 0);
    endtask

    task automatic t_no_splice();
        scan({KEY[31:0], 32'hDEAD_BEEF}, 64, 1, 0);
        scan({32'h0, KEY[63:32]}, 32, 1, 1);
        chk(emu_unlock == 0, "R3 partial key splice", emu_unlock, 0);
    endtask

    task automatic t_continuity();
        scan(KEY, 64, 1, 0);
        chk(outbits == 64'h0, "R11 zeros after capture", outbits, 0);
        scan(64'h0, 64, 0, 0);
        chk(outbits == KEY, "R4 R5 tdo order", outbits, KEY);
        scan(64'h0, 64, 0, 0);
        chk(outbits == 64'h0, "R11 no stored key on tdo", outbits, 0);
    endtask

    task automatic t_update_gate();
        scan(KEY, 64, 1, 0);
        repeat (5) @(negedge clk);
        chk(emu_unlock == 0, "R9 no update no unlock", emu_unlock, 0);
        dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
        chk(emu_unlock == 1 && boot_unlock == 1, "R6 unlock both", {emu_unlock, boot_unlock}, 2'b11);
    endtask

    task automatic t_sticky();
        scan(~KEY, 64, 1, 1);
        chk(emu_unlock == 1 && boot_unlock == 1, "R8 stays after wrong key", {emu_unlock, boot_unlock}, 2'b11);
        scan(64'h0, 64, 1, 1);
        chk(boot_unlock == 1, "R8 stays after zero key", boot_unlock, 1);
        do_reset(1'b1);
        chk(emu_unlock == 0 && boot_unlock == 0, "R1 R8 relock on reset", {emu_unlock, boot_unlock}, 0);
    endtask

    task automatic t_capture_priority();
        scan(64'hFFFF_FFFF_FFFF_FFFF, 64, 1, 0);
        dr_capture = 1'b1;
        dr_shift = 1'b1;
        tdi = 1'b1;
        @(negedge clk);
        dr_capture = 1'b0;
        dr_shift = 1'b0;
        tdi = 1'b0;
        chk(tdo == 0, "R3 capture over shift", tdo, 0);
    endtask

    task automatic t_strap_low();
        do_reset(1'b0);
        chk(emu_unlock == 1 && boot_unlock == 1, "R2 unsecured open", {emu_unlock, boot_unlock}, 2'b11);
        scan(~KEY, 64, 1, 1);
        chk(emu_unlock == 1 && boot_unlock == 1, "R2 R8 wrong key unsecured", {emu_unlock, boot_unlock}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_locked();
        t_wrong_key();
        t_no_splice();
        t_continuity();
        t_capture_priority();
        t_update_gate();
        t_sticky();
        t_strap_low();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule